// File: doc/BRIEF.md
# LED Panel Bit-Plane Scan Driver

This block refreshes a 64 by 32 RGB LED matrix panel with a shift-register interface. It reads a frame memory that holds one 16-bit word per pixel and drives the panel's serial colour lines, shift clock, latch, active-low output enable and row select. The panel is lit as two halves at once, so each row select value covers one row in the upper half and the row sixteen lines below it. A single memory read returns both pixels of that pair.

Brightness comes from binary-weighted bit planes. Each row is shifted out four times, once per colour bit, least significant first. After each pass the row is latched and the output enable is pulsed low for a time that doubles from one plane to the next. All scan logic advances on a step that occurs once every four system clocks. A single counter serves as the column index while shifting and as the on-time timer while the strobe is active.

Top module: `hub75_scan_driver`

## Requirements
- R1: The scan advances once every 4 system clocks. While shifting, `pclk` rises every 4 clocks, is low for the first half of each step and high for the second half, and is high for at least 2 clocks.
- R2: Each bit plane of a row produces exactly 64 `pclk` rising edges. These are followed by one step with `pclk` idle and then one step with `lat` high.
- R3: Per bit plane the block issues exactly 64 read strobes (`rd_en` high while the step is active), with `rd_addr` = {row, column} (row in bits 9:6, column in bits 5:0) and the column rising 0 to 63. Reads occur only while `oe_n` is high and `lat` is low.
- R4: At the k-th `pclk` rise of a plane p, `rgb_top` = {word[8+p], word[4+p], word[p]} of the upper-half word for column k, and `rgb_bot` takes the same bits of the lower-half word. Red is in word bits 11:8, green in 7:4 and blue in 3:0. Memory data is due one clock after the read strobe and must hold until the next strobe.
- R5: `lat` is high for exactly one step (4 clocks), with `pclk` low and `oe_n` high. `oe_n` falls on the same clock edge on which `lat` falls.
- R6: For bit plane p, `oe_n` stays low for 31·2^p steps (124, 248, 496 and 992 clocks).
- R7: Planes run 0,1,2,3 for one row, then `row_sel` advances by one and wraps from 15 to 0. `row_sel` holds steady while `oe_n` is low and equals the row being displayed.
- R8: A synchronous active-high `rst` forces `oe_n` high, `lat` low, `pclk` low, `row_sel` to 0 and the scan to the start of plane 0 of row 0. This also applies in the middle of a strobe.
- R9: Pixel word bits 15:12 have no effect on the colour outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_top | input | 16 | Frame memory word for the upper-half pixel |
| mem_bot | input | 16 | Frame memory word for the lower-half pixel |
| rd_en | output | 1 | Read strobe to the frame memory |
| rd_addr | output | 10 | Read address {row, column} |
| pclk | output | 1 | Panel shift clock |
| rgb_top | output | 3 | Upper-half colour bits {red, green, blue} |
| rgb_bot | output | 3 | Lower-half colour bits {red, green, blue} |
| lat | output | 1 | Panel latch |
| oe_n | output | 1 | Panel output enable, active low |
| row_sel | output | 4 | Row-pair select |

## Verification
The bench builds the block with its default parameters: a two-bit clock divider, 64 columns, 16 row pairs, 4 bits per colour, a 10-bit counter and a base strobe of 31. With these values the longest strobe (992 clocks) fits the counter, and a whole frame takes about fifty thousand clocks, so the run covers every row, the wrap of the row select and a reset in the middle of a strobe. The bench's memory model holds nonzero data in the unused top nibble of every word, so any leak of those bits into the colour outputs shows up as a data mismatch.

// File: rtl/hub75_scan_pkg.sv
package hub75_scan_pkg;
  // Scan phases in the order they are visited
  typedef enum logic [2:0] {
    SC_SHIFT  = 3'd0,
    SC_GAP    = 3'd1,
    SC_LATCH  = 3'd2,
    SC_STROBE = 3'd3,
    SC_ROWEND = 3'd4,
    SC_NEXT   = 3'd5
  } scan_state_t;
endpackage

// File: rtl/hub75_step_gen.sv
module hub75_step_gen #(
  parameter int DIV_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  output logic step,
  output logic mid
);
  localparam logic [DIV_BITS-1:0] DIV_LAST = '1;
  localparam logic [DIV_BITS-1:0] DIV_MID  = DIV_BITS'((1 << (DIV_BITS - 1)) - 1);

  logic [DIV_BITS-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + DIV_BITS'(1);
  end

  // step: last clock of a scan step; mid: clock before the second half
  assign step = (div_q == DIV_LAST);
  assign mid  = (div_q == DIV_MID);
endmodule

// File: rtl/hub75_scan_seq.sv
module hub75_scan_seq
  import hub75_scan_pkg::*;
#(
  parameter int COL_W       = 6,
  parameter int ROW_W       = 4,
  parameter int CH_BITS     = 4,
  parameter int CNT_W       = 10,
  parameter int STROBE_BASE = 31
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        step,
  output logic [ROW_W-1:0]            row_q,
  output logic [$clog2(CH_BITS)-1:0]  plane_q,
  output logic [COL_W-1:0]            rd_col,
  output logic                        rd_en,
  output logic                        cap,
  output logic                        lat_q,
  output logic                        oe_n_q
);
  localparam int PLANE_W = $clog2(CH_BITS);
  localparam logic [PLANE_W-1:0] PLANE_LAST = PLANE_W'(CH_BITS - 1);
  localparam logic [CNT_W-1:0]   COL_END    = CNT_W'(1 << COL_W);
  localparam logic [CNT_W-1:0]   LEN_BASE   = CNT_W'(STROBE_BASE);

  scan_state_t      state_q;
  logic [CNT_W-1:0] cnt_q;   // column index, then strobe timer
  logic [CNT_W-1:0] len_q;   // strobe length of the current plane

  // Memory is read for columns 0..63; the word read at one step is
  // shown on the panel lines one step later (cap).
  assign rd_en  = step && (state_q == SC_SHIFT) && (cnt_q < COL_END);
  assign cap    = step && (state_q == SC_SHIFT) && (cnt_q != '0);
  assign rd_col = cnt_q[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SC_SHIFT;
      cnt_q   <= '0;
      len_q   <= LEN_BASE;
      plane_q <= '0;
      row_q   <= '0;
      lat_q   <= 1'b0;
      oe_n_q  <= 1'b1;
    end else if (step) begin
      unique case (state_q)
        SC_SHIFT: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == COL_END) state_q <= SC_GAP;
        end
        SC_GAP: begin
          state_q <= SC_LATCH;
        end
        SC_LATCH: begin
          lat_q   <= 1'b1;
          cnt_q   <= '0;
          state_q <= SC_STROBE;
        end
        SC_STROBE: begin
          lat_q  <= 1'b0;
          oe_n_q <= 1'b0;
          cnt_q  <= cnt_q + CNT_W'(1);
          if (cnt_q == len_q) begin
            oe_n_q  <= 1'b1;
            state_q <= SC_ROWEND;
          end
        end
        SC_ROWEND: begin
          if (plane_q == PLANE_LAST) begin
            plane_q <= '0;
            len_q   <= LEN_BASE;
            row_q   <= row_q + ROW_W'(1);
          end else begin
            plane_q <= plane_q + PLANE_W'(1);
            len_q   <= len_q << 1;
          end
          state_q <= SC_NEXT;
        end
        SC_NEXT: begin
          cnt_q   <= '0;
          state_q <= SC_SHIFT;
        end
        default: state_q <= SC_SHIFT;
      endcase
    end
  end
endmodule

// File: rtl/hub75_pixel_out.sv
module hub75_pixel_out #(
  parameter int CH_BITS = 4,
  parameter int PIX_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic                       mid,
  input  logic                       cap,
  input  logic [$clog2(CH_BITS)-1:0] plane,
  input  logic [1:0][PIX_W-1:0]      words,
  output logic                       pclk,
  output logic [1:0][2:0]            rgb
);
  logic gate_q;

  // Clock runs only for steps that carry a fresh column
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      pclk   <= 1'b0;
    end else if (step) begin
      gate_q <= cap;
      pclk   <= 1'b0;
    end else if (mid) begin
      pclk <= gate_q;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst) begin
        rgb[h] <= '0;
      end else if (cap) begin
        rgb[h] <= {words[h][2*CH_BITS + int'(plane)],
                   words[h][CH_BITS + int'(plane)],
                   words[h][int'(plane)]};
      end
    end
  end

  // Bits above the three colour fields are not displayed
  logic unused_hi;
  assign unused_hi = ^{words[0][PIX_W-1:3*CH_BITS], words[1][PIX_W-1:3*CH_BITS]};
endmodule

// File: rtl/hub75_scan_driver.sv
module hub75_scan_driver #(
  parameter int DIV_BITS    = 2,
  parameter int COL_W       = 6,
  parameter int ROW_W       = 4,
  parameter int CH_BITS     = 4,
  parameter int PIX_W       = 16,
  parameter int CNT_W       = 10,
  parameter int STROBE_BASE = 31,
  localparam int ADDR_W     = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  mem_top,
  input  logic [PIX_W-1:0]  mem_bot,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pclk,
  output logic [2:0]        rgb_top,
  output logic [2:0]        rgb_bot,
  output logic              lat,
  output logic              oe_n,
  output logic [ROW_W-1:0]  row_sel
);
  localparam int PLANE_W = $clog2(CH_BITS);

  logic               step, mid, cap;
  logic [PLANE_W-1:0] plane;
  logic [COL_W-1:0]   rd_col;
  logic [1:0][2:0]    rgb_pair;

  hub75_step_gen #(.DIV_BITS(DIV_BITS)) u_step (
    .clk (clk),
    .rst (rst),
    .step(step),
    .mid (mid)
  );

  hub75_scan_seq #(
    .COL_W      (COL_W),
    .ROW_W      (ROW_W),
    .CH_BITS    (CH_BITS),
    .CNT_W      (CNT_W),
    .STROBE_BASE(STROBE_BASE)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .row_q  (row_sel),
    .plane_q(plane),
    .rd_col (rd_col),
    .rd_en  (rd_en),
    .cap    (cap),
    .lat_q  (lat),
    .oe_n_q (oe_n)
  );

  hub75_pixel_out #(.CH_BITS(CH_BITS), .PIX_W(PIX_W)) u_out (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .mid  (mid),
    .cap  (cap),
    .plane(plane),
    .words({mem_bot, mem_top}),
    .pclk (pclk),
    .rgb  (rgb_pair)
  );

  assign rd_addr = {row_sel, rd_col};
  assign rgb_top = rgb_pair[0];
  assign rgb_bot = rgb_pair[1];
endmodule

// File: rtl/hub75_scan_checker.sv
module hub75_scan_checker #(
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic             pclk,
  input logic             lat,
  input logic             oe_n,
  input logic [ROW_W-1:0] row_sel
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b1;
  end

  AST_PCLK_WIDE: assert property (@(posedge clk) disable iff (rst)
    $rose(pclk) |=> pclk); // R1
  AST_READ_DARK: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (oe_n && !lat)); // R3
  AST_LAT_DARK: assert property (@(posedge clk) disable iff (rst)
    lat |-> (oe_n && !pclk)); // R5
  AST_OE_ON_LAT_FALL: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $fell(lat)) |-> !oe_n); // R5
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !oe_n && !$past(oe_n)) |-> $stable(row_sel)); // R7
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(rst)) |-> (oe_n && !lat && !pclk && row_sel == '0)); // R8
endmodule

bind hub75_scan_driver hub75_scan_checker #(.ROW_W(ROW_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rd_en  (rd_en),
  .pclk   (pclk),
  .lat    (lat),
  .oe_n   (oe_n),
  .row_sel(row_sel)
);

// File: tb/hub75_scan_driver_test.sv
module hub75_scan_driver_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [15:0] mem_top = '0, mem_bot = '0;
  logic       rd_en, pclk, lat, oe_n;
  logic [9:0] rd_addr;
  logic [2:0] rgb_top, rgb_bot;
  logic [3:0] row_sel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hub75_scan_driver uut (
    .clk(clk), .rst(rst), .mem_top(mem_top), .mem_bot(mem_bot),
    .rd_en(rd_en), .rd_addr(rd_addr), .pclk(pclk),
    .rgb_top(rgb_top), .rgb_bot(rgb_bot), .lat(lat), .oe_n(oe_n),
    .row_sel(row_sel)
  );

  // Test image; top nibble always nonzero (R9)
  function automatic logic [15:0] pix(int r, int c);
    return {4'(c + r) | 4'h8, 4'(c ^ r), 4'(c + 3 * r), 4'(5 * c + r)};
  endfunction

  function automatic logic [2:0] exp_bits(int r, int c, int p);
    logic [15:0] w;
    w = pix(r, c);
    return {w[8 + p], w[4 + p], w[p]};
  endfunction

  // Frame memory model: data one clock after the strobe, held until next
  always @(posedge clk) begin
    if (rd_en) begin
      mem_top <= pix(int'(rd_addr[9:6]), int'(rd_addr[5:0]));
      mem_bot <= pix(int'(rd_addr[9:6]) + 16, int'(rd_addr[5:0]));
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Follow one bit plane from first shift to the end of its strobe
  task automatic capture_plane(input int erow, input int eplane, input int eoe);
    int n = 0, nrd = 0, cyc = 0, last = 0;
    int bad_d = 0, bad_p = 0, bad_a = 0, bad_row = 0, latc = 0, oec = 0;
    logic prevp;
    prevp = pclk;
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_en) begin
        if (rd_addr != {4'(erow), 6'(nrd)}) bad_a++;
        nrd++;
      end
      if (pclk && !prevp) begin
        if (n > 0 && cyc - last != 4) bad_p++;
        last = cyc;
        if (n < 64)
          if (rgb_top != exp_bits(erow, n, eplane) ||
              rgb_bot != exp_bits(erow + 16, n, eplane)) bad_d++;
        n++;
      end
      prevp = pclk;
      if (lat) break;
    end
    chk(n == 64, "R2", "pclk rises per plane", n, 64);
    chk(nrd == 64, "R3", "reads per plane", nrd, 64);
    chk(bad_a == 0, "R3", "bad read addresses", bad_a, 0);
    chk(bad_d == 0, "R4 R9", "colour mismatches", bad_d, 0);
    chk(bad_p == 0, "R1", "pclk pitch errors", bad_p, 0);
    chk(pclk == 1'b0, "R5", "pclk at latch", int'(pclk), 0);
    chk(oe_n == 1'b1, "R5", "oe_n at latch", int'(oe_n), 1);
    while (lat) begin
      latc++;
      @(negedge clk);
    end
    chk(latc == 4, "R5", "latch clocks", latc, 4);
    chk(oe_n == 1'b0, "R5", "oe_n after latch", int'(oe_n), 0);
    while (!oe_n) begin
      if (row_sel != 4'(erow)) bad_row++;
      oec++;
      @(negedge clk);
    end
    chk(oec == eoe, "R6", "oe_n low clocks", oec, eoe);
    chk(bad_row == 0, "R7", "row_sel during strobe", bad_row, 0);
  endtask

  task automatic check_reset_state(input string tag);
    chk(oe_n == 1'b1, "R8", {tag, " oe_n"}, int'(oe_n), 1);
    chk(lat == 1'b0, "R8", {tag, " lat"}, int'(lat), 0);
    chk(pclk == 1'b0, "R8", {tag, " pclk"}, int'(pclk), 0);
    chk(row_sel == 4'd0, "R8", {tag, " row_sel"}, int'(row_sel), 0);
    chk(rd_en == 1'b0, "R8", {tag, " rd_en"}, int'(rd_en), 0);
  endtask

  // {row, plane, oe_n low clocks}
  localparam logic [19:0] PLAN [8] = '{
    {4'd0, 4'd0, 12'd124}, {4'd0, 4'd1, 12'd248},
    {4'd0, 4'd2, 12'd496}, {4'd0, 4'd3, 12'd992},
    {4'd1, 4'd0, 12'd124}, {4'd1, 4'd1, 12'd248},
    {4'd1, 4'd2, 12'd496}, {4'd1, 4'd3, 12'd992}
  };

  initial begin
    repeat (4) @(negedge clk);
    check_reset_state("power-on");
    rst = 1'b0;

    // R6 R7: first two rows from the table
    for (int i = 0; i < 8; i++)
      capture_plane(int'(PLAN[i][19:16]), int'(PLAN[i][15:12]), int'(PLAN[i][11:0]));

    // Rest of the frame, then the R7 wrap back to row 0
    for (int r = 2; r < 16; r++)
      for (int p = 0; p < 4; p++)
        capture_plane(r, p, 124 << p);
    for (int p = 0; p < 4; p++)
      capture_plane(0, p, 124 << p);
    capture_plane(1, 0, 124);

    // R8: reset in the middle of a strobe on row 1
    while (oe_n) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("mid-strobe");
    rst = 1'b0;
    capture_plane(0, 0, 124);
    capture_plane(0, 1, 248);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule